// File: doc/BRIEF.md
# Two-Thread Issue Arbiter with Spin-Wait Stall Window

This block decides, every cycle, which of two hardware threads on one core may use a single shared issue slot. Threads with a ready micro-op take turns. When decode reports a spin-wait hint for a thread, that thread is held off the slot for a fixed stall window. During that window the sibling thread may claim every slot. The window is short by default and can be switched to a long setting.

Each thread also has a small counter of spin-wait hints. The counter is cleared whenever the thread actually issues. When the count reaches a threshold, the block emits a one-cycle request to leave the guest. The window setting and the threshold come from configuration inputs. They are captured only on a cycle in which the block is completely idle, so a window that is already running never changes length.

Top module: `smt_issue_arb`

## Requirements
- R1: `issue_grant` has at most one bit set, and a grant never goes to a thread whose `uop_valid` is low or whose `thread_stalled` is high.
- R2: When both threads are valid and neither is stalled, the grant alternates, going to the thread not granted most recently; after reset thread 0 (bit 0) is granted first.
- R3: When only one thread is valid and not stalled, that thread receives the grant every cycle, including while its sibling is stalled.
- R4: A `pause_hint` bit raises `thread_stalled` for that thread in the same cycle and keeps it high for exactly L cycles counting that cycle, where L is SHORT_LEN (10) when the captured mode is short and LONG_LEN (140) when `cfg_long_win` was 1 at capture.
- R5: A hint arriving while the thread is already stalled restarts the window, so the stall lasts L cycles counted from the newest hint.
- R6: When no thread is both valid and unstalled, `issue_grant` is 0.
- R7: Each hint adds one to that thread's hint count. The hint that brings the count to the captured threshold T (T≠0) produces `vm_exit_req` for that thread for exactly one cycle, in the cycle after the hint, and the count returns to zero. A threshold of 0 never produces a request. The count saturates at its maximum.
- R8: A granted micro-op of a thread clears that thread's hint count to zero.
- R9: `cfg_long_win` and `cfg_exit_thresh` are captured only at a clock edge where both `uop_valid` bits and both `pause_hint` bits are 0 and no window is running. Changes at other times have no effect. After reset the mode is short and the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uop_valid | input | 2 | Per-thread ready micro-op |
| pause_hint | input | 2 | Per-thread spin-wait hint from decode |
| cfg_long_win | input | 1 | Window mode: 1 selects the long window |
| cfg_exit_thresh | input | CNT_W | Hint count that triggers a guest exit request (0 disables) |
| issue_grant | output | 2 | One-hot issue grant |
| thread_stalled | output | 2 | Per-thread stall status |
| vm_exit_req | output | 2 | Per-thread one-cycle guest exit request |

## Verification
The hardest case to reach is a configuration change that arrives while a thread is busy or stalled. It must be ignored, and the proof is that the next window length and the next exit request still follow the old values. The stimulus first brings the block to an idle edge with one setting. It then changes both configuration inputs while the sibling thread is valid and hints are in flight. Later it drains to idle and confirms that the new values take hold only then. A bench model of per-thread windows and counts predicts every output, so restarts and hints that land inside a window are checked cycle by cycle. Those cases come from an exhaustive sweep of valid and hint patterns, followed by directed runs in both window modes.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;
  localparam int unsigned NTHR = 2;
  typedef logic [NTHR-1:0] thr_vec_t;

  // last = index of the thread granted most recently
  function automatic thr_vec_t rr_pick(input thr_vec_t elig, input logic last);
    case (elig)
      2'b11:   return last ? 2'b01 : 2'b10;
      2'b01:   return 2'b01;
      2'b10:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/smt_rr_sel.sv
module smt_rr_sel
  import smt_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  thr_vec_t elig,
  output thr_vec_t grant
);
  logic last_q;

  assign grant = rr_pick(elig, last_q);

  always_ff @(posedge clk) begin
    if (!rst_n)          last_q <= 1'b1;
    else if (|grant)     last_q <= grant[1];
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R1
  AST_RR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == 2'b11) |=> (elig != 2'b11) || (grant != $past(grant))); // R2
  AST_SOLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(elig) == 1) |-> (grant == elig)); // R3
endmodule

// File: rtl/smt_pause_win.sv
module smt_pause_win #(
  parameter int unsigned WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hint,
  input  logic [WIN_W-1:0] len,
  output logic             busy,
  output logic             stalled
);
  localparam logic [WIN_W-1:0] WIN_ONE = WIN_W'(1);

  // the hint cycle itself is stall cycle one
  function automatic logic [WIN_W-1:0] reload(input logic [WIN_W-1:0] l);
    return (l == '0) ? '0 : l - WIN_ONE;
  endfunction

  logic [WIN_W-1:0] cnt_q;

  assign busy    = (cnt_q != '0);
  assign stalled = hint | busy;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (hint)   cnt_q <= reload(len);
    else if (busy)   cnt_q <= cnt_q - WIN_ONE;
  end

  AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (hint && len > WIN_ONE) |=> busy); // R5
  AST_WIN_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!hint && busy) |=> (cnt_q < $past(cnt_q))); // R4
  AST_WIN_NO_SELF_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hint && !busy) |=> !busy); // R4
endmodule

// File: rtl/smt_exit_ctr.sv
module smt_exit_ctr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hint,
  input  logic             issued,
  input  logic [CNT_W-1:0] thresh,
  output logic             exit_o
);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_MAX = '1;

  function automatic logic hit(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    return (t != '0) && (({1'b0, c} + {1'b0, C_ONE}) >= {1'b0, t});
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return (c == C_MAX) ? C_MAX : c + C_ONE;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             fire;

  assign fire = hint && hit(cnt_q, thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      exit_o <= 1'b0;
    end else begin
      exit_o <= fire;
      if (fire)        cnt_q <= '0;
      else if (hint)   cnt_q <= bump(cnt_q);
      else if (issued) cnt_q <= '0;
    end
  end

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (issued && !hint) |=> (cnt_q == '0)); // R8
  AST_EXIT_FROM_HINT: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |-> ($past(hint) && $past(thresh) != '0)); // R7
endmodule

// File: rtl/smt_issue_arb.sv
module smt_issue_arb
  import smt_arb_pkg::*;
#(
  parameter int unsigned SHORT_LEN = 10,
  parameter int unsigned LONG_LEN  = 140,
  parameter int unsigned CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       uop_valid,
  input  logic [1:0]       pause_hint,
  input  logic             cfg_long_win,
  input  logic [CNT_W-1:0] cfg_exit_thresh,
  output logic [1:0]       issue_grant,
  output logic [1:0]       thread_stalled,
  output logic [1:0]       vm_exit_req
);
  localparam int unsigned      WIN_W   = $clog2(LONG_LEN + 1);
  localparam logic [WIN_W-1:0] SHORT_V = WIN_W'(SHORT_LEN);
  localparam logic [WIN_W-1:0] LONG_V  = WIN_W'(LONG_LEN);

  logic [WIN_W-1:0] len_q;
  logic [CNT_W-1:0] thr_q;
  thr_vec_t         win_busy;
  thr_vec_t         elig;
  logic             idle;

  assign idle = ~|uop_valid & ~|pause_hint & ~|win_busy;
  assign elig = uop_valid & ~thread_stalled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= SHORT_V;
      thr_q <= '0;
    end else if (idle) begin
      len_q <= cfg_long_win ? LONG_V : SHORT_V;
      thr_q <= cfg_exit_thresh;
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    smt_pause_win #(.WIN_W(WIN_W)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .hint    (pause_hint[g]),
      .len     (len_q),
      .busy    (win_busy[g]),
      .stalled (thread_stalled[g])
    );
    smt_exit_ctr #(.CNT_W(CNT_W)) u_exit (
      .clk    (clk),
      .rst_n  (rst_n),
      .hint   (pause_hint[g]),
      .issued (issue_grant[g]),
      .thresh (thr_q),
      .exit_o (vm_exit_req[g])
    );
  end

  smt_rr_sel u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig),
    .grant (issue_grant)
  );

  AST_NO_STALLED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_grant & (thread_stalled | ~uop_valid)) == 2'b00)); // R1
  AST_NONE_ELIG_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ((uop_valid & ~thread_stalled) == 2'b00) |-> (issue_grant == 2'b00)); // R6
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (|uop_valid || |pause_hint || |win_busy) |=> ($stable(len_q) && $stable(thr_q))); // R9
endmodule

// File: tb/sim_smt_issue_arb.sv
`timescale 1ns/100ps
module sim_smt_issue_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] uop_valid = '0;
  logic [1:0] pause_hint = '0;
  logic       cfg_long_win = 1'b0;
  logic [3:0] cfg_exit_thresh = '0;
  logic [1:0] issue_grant, thread_stalled, vm_exit_req;

  int n_chk = 0, n_bad = 0;
  logic       nxt_long = 1'b0;
  logic [3:0] nxt_thr = '0;

  // bench model state
  int   m_len = 10, m_thr = 0;
  int   m_rem[2] = '{0, 0};
  int   m_cnt[2] = '{0, 0};
  logic m_last = 1'b1;
  logic [1:0] m_pend = '0;

  always #2.5 clk = ~clk;

  smt_issue_arb u0 (
    .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .pause_hint(pause_hint),
    .cfg_long_win(cfg_long_win), .cfg_exit_thresh(cfg_exit_thresh),
    .issue_grant(issue_grant), .thread_stalled(thread_stalled), .vm_exit_req(vm_exit_req)
  );

  task automatic check(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] v, input logic [1:0] h, input string tag);
    logic [1:0] st, el, eg;
    logic idle;
    @(negedge clk);
    uop_valid = v; pause_hint = h;
    cfg_long_win = nxt_long; cfg_exit_thresh = nxt_thr;
    #1;
    idle = (v == 2'b00) && (h == 2'b00) && (m_rem[0] == 0) && (m_rem[1] == 0);
    for (int t = 0; t < 2; t++) if (h[t]) m_rem[t] = m_len;
    for (int t = 0; t < 2; t++) st[t] = (m_rem[t] != 0);
    el = v & ~st;
    if (el == 2'b11)      eg = m_last ? 2'b01 : 2'b10;
    else                  eg = el;
    check(tag, "grant", issue_grant, eg);
    check(tag, "stalled", thread_stalled, st);
    check(tag, "vm_exit", vm_exit_req, m_pend);
    if (eg != 2'b00) m_last = eg[1];
    for (int t = 0; t < 2; t++) begin
      m_pend[t] = 1'b0;
      if (h[t]) begin
        if (m_thr != 0 && m_cnt[t] + 1 >= m_thr) begin
          m_pend[t] = 1'b1; m_cnt[t] = 0;
        end else if (m_cnt[t] < 15) m_cnt[t]++;
      end else if (eg[t]) m_cnt[t] = 0;
      if (m_rem[t] > 0) m_rem[t]--;
    end
    if (idle) begin
      m_len = nxt_long ? 140 : 10;
      m_thr = int'(nxt_thr);
    end
  endtask

  // drain to idle and capture a new configuration (R9)
  task automatic settle(input logic lng, input logic [3:0] thr);
    nxt_long = lng; nxt_thr = thr;
    while (m_rem[0] != 0 || m_rem[1] != 0) step(2'b00, 2'b00, "R9");
    step(2'b00, 2'b00, "R9");
    step(2'b00, 2'b00, "R9");
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R6", "reset grant", issue_grant, 2'b00);
    check("R4", "reset stalled", thread_stalled, 2'b00);
    check("R7", "reset vm_exit", vm_exit_req, 2'b00);
    @(negedge clk); rst_n = 1'b1;

    settle(1'b0, 4'd3);
    // R2: alternation from thread 0 after reset
    repeat (8) step(2'b11, 2'b00, "R2");
    // R3: a lone thread takes every slot
    repeat (4) step(2'b01, 2'b00, "R3");
    repeat (4) step(2'b10, 2'b00, "R3");
    // R6: nothing valid
    repeat (3) step(2'b00, 2'b00, "R6");

    // R1: near-exhaustive sweep of valid/hint patterns
    for (int i = 0; i < 64; i++) begin
      logic [5:0] k;
      k = i[5:0];
      step(k[1:0], (k[5:4] == 2'b00) ? k[3:2] : 2'b00, "R1");
    end
    settle(1'b0, 4'd0);

    // R4: window length in both modes, each thread; R3 sibling gets all slots
    for (int md = 0; md < 2; md++) begin
      for (int t = 0; t < 2; t++) begin
        logic [1:0] hv;
        settle(md[0], 4'd0);
        hv = (t == 0) ? 2'b01 : 2'b10;
        step(2'b11, hv, "R4");
        repeat (m_len + 3) step(2'b11, 2'b00, "R4");
      end
    end

    // R6: both threads stalled, both valid
    settle(1'b0, 4'd0);
    step(2'b11, 2'b11, "R6");
    repeat (4) step(2'b11, 2'b00, "R6");

    // R5: restart inside the window
    settle(1'b0, 4'd0);
    step(2'b11, 2'b01, "R5");
    repeat (5) step(2'b11, 2'b00, "R5");
    step(2'b11, 2'b01, "R5");
    repeat (12) step(2'b11, 2'b00, "R5");

    // R7: threshold 3, hints every other cycle with no issue
    settle(1'b0, 4'd3);
    for (int i = 0; i < 7; i++) begin
      step(2'b00, 2'b10, "R7");
      step(2'b00, 2'b00, "R7");
    end
    // R7: threshold 0 never fires; count saturates
    settle(1'b0, 4'd0);
    repeat (20) step(2'b00, 2'b01, "R7");
    repeat (3) step(2'b00, 2'b00, "R7");

    // R8: an issued micro-op clears the count
    settle(1'b0, 4'd3);
    step(2'b00, 2'b01, "R8");
    step(2'b00, 2'b01, "R8");
    repeat (12) step(2'b01, 2'b00, "R8");
    step(2'b00, 2'b01, "R8");
    step(2'b00, 2'b01, "R8");
    step(2'b00, 2'b00, "R8");
    step(2'b00, 2'b01, "R8");
    repeat (3) step(2'b00, 2'b00, "R8");

    // R9: configuration change while busy is ignored
    settle(1'b0, 4'd2);
    nxt_long = 1'b1; nxt_thr = 4'd1;
    step(2'b10, 2'b01, "R9");
    repeat (3) step(2'b10, 2'b00, "R9");
    step(2'b10, 2'b01, "R9");
    repeat (12) step(2'b10, 2'b00, "R9");
    settle(1'b1, 4'd1);
    step(2'b11, 2'b01, "R9");
    repeat (142) step(2'b11, 2'b00, "R9");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule